// File: doc/BRIEF.md
# Two-Address I2C Slave Register Port

This block is a slave-only I2C target that runs entirely on an internal system clock. It never drives SCL and never creates START or STOP conditions. SCL and the incoming serial data are oversampled through a synchronizer. Edges found in the synchronized samples drive a byte engine. That engine catches START and STOP, takes in the address byte and compares it against one of two 7-bit addresses. A strap pin picks which address applies.

Serial data enters on a dedicated input pin and leaves on a separate output pin. The output pin is an open-drain style pull: 0 pulls the line low and 1 releases it. On a board the two pins are joined to one wired-AND line. After a write address, the first data byte sets a register index and every later byte is stored at that index. After a read address, the block returns bytes starting from the current index. The index auto-increments in both directions.

A local port gives the rest of the chip direct write and registered read access to the same register bank. The system clock must run at least ten times faster than SCL, and SCL may run up to 400 kHz.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, sda_out is 1 (released) and every register in the bank reads 0 through the local port.
- R2: A rising data edge while SCL is high (STOP) returns the block to idle with sda_out released. Bytes clocked after a STOP without a new START are not acknowledged and do not change any register.
- R3: The 7-bit address is 0x1C when addr_sel is 0 and 0x1D when it is 1. The address bits are sent MSB first, followed by a R/W bit that is 1 for read and 0 for write. On a match, sda_out is low during the ninth SCL clock.
- R4: After a non-matching address byte, no acknowledge is given and no register is written until the next START.
- R5: In a write, the first data byte after the address sets the register index from its low REG_AW bits. Each following byte is stored at the index, the index then increments and wraps from 2^REG_AW-1 to 0, and every byte is acknowledged.
- R6: In a read, bytes are returned MSB first starting at the current index. The index increments after each byte, and the block keeps sending while the master acknowledges.
- R7: When the master does not acknowledge a read byte, sda_out stays released for all further clocks until the next START.
- R8: A repeated START, given without a STOP, restarts address reception, so a write of the index can be followed by a read.
- R9: sda_out changes only after a synchronized SCL falling edge (or a START/STOP), never in the middle of an SCL high phase.
- R10: The local port writes loc_wdata to register loc_addr when loc_we is 1. loc_rdata shows register loc_addr one clock after the address is applied. A bus write in the same cycle takes priority.
- R11: Bytes written over the bus are visible on the local read port, and bytes written through the local port are returned by a bus read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data from the bus |
| sda_out | output | 1 | Serial data pull: 0 pulls the line low, 1 releases it |
| addr_sel | input | 1 | Strap choosing the 7-bit address 0x1C (0) or 0x1D (1) |
| loc_we | input | 1 | Local write enable |
| loc_addr | input | REG_AW | Local register index |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data, registered |

## Verification
The serial output answers an SCL edge about four system cycles later: two synchronizer stages, one cycle for edge detection and the output register. The bench therefore changes its data line a quarter SCL period (10 cycles) after each falling edge. It samples the acknowledge and read bits 10 cycles into each 20-cycle high phase, well after the reply has settled. Local read data is due one rising edge after loc_addr is applied, so the bench sets the address on one falling edge and reads on the next. A monitor flags any change of sda_out that appears more than four cycles into an SCL high phase.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } phase_t;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cs_sampler.sv
module i2cs_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_q, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC-2:0], sda_in};
      scl_p  <= scl_q;
      sda_p  <= sda_q;
    end
  end

  assign scl_q     = scl_ff[SYNC-1];
  assign sda_q     = sda_ff[SYNC-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      b_rdata <= '0;
    end else begin
      if (a_we)      mem[a_addr] <= a_wdata;
      else if (b_we) mem[b_addr] <= b_wdata;
      b_rdata <= mem[b_addr];
    end
  end

  assign a_rdata = mem[a_addr];
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int       AW      = 4,
  parameter bit [6:0] ADDR_LO = 7'h1C,
  parameter bit [6:0] ADDR_HI = 7'h1D
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_sel,
  input  logic          sda_q,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_byte,
  output logic          sda_o,
  output logic          wr_en,
  output logic [AW-1:0] idx,
  output logic [7:0]    wr_data,
  output phase_t        phase,
  output logic [3:0]    bcnt
);
  logic [7:0] sh, tx;
  logic       rw;
  logic [6:0] my_addr;
  logic       active;

  assign my_addr = addr_sel ? ADDR_HI : ADDR_LO;
  assign active  = (phase != PH_IDLE) && (phase != PH_SKIP);
  assign wr_data = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      bcnt  <= '0;
      sh    <= '0;
      tx    <= '0;
      idx   <= '0;
      rw    <= 1'b0;
      sda_o <= 1'b1;
      wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase <= PH_ADDR;
        bcnt  <= '0;
        sda_o <= 1'b1;
      end else if (stop_det) begin
        phase <= PH_IDLE;
        bcnt  <= '0;
        sda_o <= 1'b1;
      end else if (scl_rise && active) begin
        if (bcnt < 4'd8) sh <= {sh[6:0], sda_q};
        if (bcnt == 4'd8 && phase == PH_READ && sda_q) phase <= PH_SKIP;
        if (bcnt < 4'd9) bcnt <= bcnt + 4'd1;
      end else if (scl_fall && active) begin
        if (bcnt == 4'd8) begin
          case (phase)
            PH_ADDR: begin
              if (sh[7:1] == my_addr) begin
                rw    <= sh[0];
                sda_o <= 1'b0;
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_INDEX: begin
              idx   <= sh[AW-1:0];
              sda_o <= 1'b0;
            end
            PH_WRITE: begin
              wr_en <= 1'b1;
              sda_o <= 1'b0;
            end
            default: sda_o <= 1'b1;
          endcase
        end else if (bcnt == 4'd9) begin
          bcnt <= '0;
          case (phase)
            PH_ADDR: begin
              if (rw) begin
                phase <= PH_READ;
                tx    <= rd_byte;
                sda_o <= rd_byte[7];
                idx   <= idx + 1'b1;
              end else begin
                phase <= PH_INDEX;
                sda_o <= 1'b1;
              end
            end
            PH_INDEX: begin
              phase <= PH_WRITE;
              sda_o <= 1'b1;
            end
            PH_WRITE: begin
              idx   <= idx + 1'b1;
              sda_o <= 1'b1;
            end
            PH_READ: begin
              tx    <= rd_byte;
              sda_o <= rd_byte[7];
              idx   <= idx + 1'b1;
            end
            default: sda_o <= 1'b1;
          endcase
        end else if (phase == PH_READ) begin
          sda_o <= tx[3'd7 - bcnt[2:0]];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cs_pkg::*;
#(
  parameter int       REG_AW      = 4,
  parameter int       SYNC_STAGES = 2,
  parameter bit [6:0] DEV_ADDR_LO = 7'h1C,
  parameter bit [6:0] DEV_ADDR_HI = 7'h1D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_out,
  input  logic              addr_sel,
  input  logic              loc_we,
  input  logic [REG_AW-1:0] loc_addr,
  input  logic [7:0]        loc_wdata,
  output logic [7:0]        loc_rdata
);
  logic              sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic              bus_we;
  logic [REG_AW-1:0] bus_idx;
  logic [7:0]        bus_wdata, bus_rdata;
  phase_t            phase;
  logic [3:0]        bcnt;

  i2cs_sampler #(.SYNC(SYNC_STAGES)) u_smp (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_engine #(.AW(REG_AW), .ADDR_LO(DEV_ADDR_LO), .ADDR_HI(DEV_ADDR_HI)) u_eng (
    .clk(clk), .rst(rst), .addr_sel(addr_sel), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_byte(bus_rdata), .sda_o(sda_out), .wr_en(bus_we),
    .idx(bus_idx), .wr_data(bus_wdata), .phase(phase), .bcnt(bcnt)
  );

  i2cs_regfile #(.AW(REG_AW), .DW(BYTE_W)) u_rf (
    .clk(clk), .rst(rst),
    .a_we(bus_we), .a_addr(bus_idx), .a_wdata(bus_wdata), .a_rdata(bus_rdata),
    .b_we(loc_we), .b_addr(loc_addr), .b_wdata(loc_wdata), .b_rdata(loc_rdata)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
  import i2cs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sda_out,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       bus_we,
  input phase_t     phase,
  input logic [3:0] bcnt
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> sda_out);

  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (sda_out && phase == PH_IDLE));

  a_r5_write_in_ack_slot: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> (!sda_out && bcnt == 4'd8));

  a_r7_skip_released: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> sda_out);

  a_r8_start_restarts: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (phase == PH_ADDR && bcnt == 4'd0));

  a_r9_change_after_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_out) |-> $past(scl_fall || start_det || stop_det));

  a_r3_bit_count_range: assert property (@(posedge clk) disable iff (rst)
    bcnt <= 4'd9);
endmodule

bind i2c_reg_slave i2cs_checker u_chk (
  .clk(clk), .rst(rst), .sda_out(sda_out), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .bus_we(bus_we),
  .phase(phase), .bcnt(bcnt)
);

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int AW = 4;
  localparam int NREG = 1 << AW;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
  logic loc_we = 1'b0;
  logic [AW-1:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;
  logic sda_out;
  wire  sda_line = m_sda & sda_out;

  int total = 0, bad = 0, r9_viol = 0, hi_cnt = 0;
  logic prev_out = 1'b1;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [4];

  always #2.5 clk = ~clk;

  i2c_reg_slave dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_out(sda_out),
    .addr_sel(addr_sel), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  // R9 monitor: no output change deep inside an SCL high phase
  always @(negedge clk) begin
    hi_cnt <= scl ? hi_cnt + 1 : 0;
    if (!rst && sda_out !== prev_out && scl && hi_cnt > 4) r9_viol <= r9_viol + 1;
    prev_out <= sda_out;
  end

  function automatic logic [7:0] addr_byte(input logic sel, input logic rd);
    return {(sel ? 7'h1D : 7'h1C), rd};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    ack = (sda_line == 1'b0);
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl = 1'b0;
    end
    wq(Q); m_sda = nack; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q); m_sda = 1'b1;
  endtask

  task automatic lread(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk) loc_addr = a;
    @(negedge clk) d = loc_rdata;
  endtask

  task automatic lwrite(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk) begin loc_we = 1'b1; loc_addr = a; loc_wdata = d; end
    @(negedge clk) loc_we = 1'b0;
    model[a] = d;
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] ix, input int n, input string req);
    logic ack;
    bus_start();
    send_byte(addr_byte(sel, 1'b0), ack); chk(ack, "R3 write address ack", ack, 1);
    send_byte(ix, ack); chk(ack, "R5 index ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); chk(ack, req, ack, 1);
      model[(ix + k) % NREG] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic bus_rd(input logic sel, input logic [7:0] ix, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(addr_byte(sel, 1'b0), ack); chk(ack, "R3 address ack", ack, 1);
    send_byte(ix, ack); chk(ack, "R5 index ack", ack, 1);
    bus_start();
    send_byte(addr_byte(sel, 1'b1), ack); chk(ack, "R8 read after repeated start", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, d);
      chk(d == model[(ix + k) % NREG], req, d, model[(ix + k) % NREG]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    wq(5); rst = 1'b0; wq(3);

    // R1 reset state
    chk(sda_out == 1'b1, "R1 sda released", sda_out, 1);
    for (int i = 0; i < NREG; i += 5) begin
      lread(AW'(i), d); chk(d == 8'h00, "R1 register zero", d, 0);
    end

    // R3/R5/R11 write at 0x1C, check on local port
    addr_sel = 1'b0;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0;
    bus_wr(1'b0, 8'h03, 3, "R5 data ack");
    for (int k = 3; k < 6; k++) begin
      lread(AW'(k), d); chk(d == model[k], "R11 bus write seen locally", d, model[k]);
    end

    // R4 wrong address with addr_sel=1, then correct one
    addr_sel = 1'b1;
    bus_start();
    send_byte(addr_byte(1'b0, 1'b0), ack); chk(!ack, "R4 no ack on mismatch", ack, 0);
    send_byte(8'h03, ack); chk(!ack, "R4 ignored byte", ack, 0);
    send_byte(8'h11, ack); chk(!ack, "R4 ignored byte", ack, 0);
    bus_stop();
    lread(AW'(3), d); chk(d == model[3], "R4 register untouched", d, model[3]);
    wbuf[0] = 8'h5E; wbuf[1] = 8'h81;
    bus_wr(1'b1, 8'h0F, 2, "R3 data ack at 0x1D");
    lread(AW'(15), d); chk(d == 8'h5E, "R5 write at top index", d, 8'h5E);
    lread(AW'(0), d);  chk(d == 8'h81, "R5 index wraps to 0", d, 8'h81);

    // R2 bytes after STOP without START are ignored
    bus_start();
    send_byte(addr_byte(1'b1, 1'b0), ack); chk(ack, "R3 ack", ack, 1);
    send_byte(8'h07, ack); chk(ack, "R5 index ack", ack, 1);
    bus_stop();
    send_byte(8'h99, ack); chk(!ack, "R2 no ack after stop", ack, 0);
    lread(AW'(7), d); chk(d == model[7], "R2 register untouched", d, model[7]);

    // R10 local write, R11 read over bus; R6 multi-byte read with wrap
    lwrite(AW'(14), 8'hC3);
    lread(AW'(14), d); chk(d == 8'hC3, "R10 local readback", d, 8'hC3);
    bus_rd(1'b1, 8'h0E, 3, "R11 R6 bus read data");

    // R7 after master nack the line stays released
    bus_start();
    send_byte(addr_byte(1'b1, 1'b1), ack); chk(ack, "R3 read address ack", ack, 1);
    recv_byte(1'b1, d);
    recv_byte(1'b1, d); chk(d == 8'hFF, "R7 released after nack", d, 8'hFF);
    bus_stop();

    // R8 repeated start with foreign address abandons write
    bus_start();
    send_byte(addr_byte(1'b1, 1'b0), ack);
    send_byte(8'h09, ack);
    bus_start();
    send_byte(8'h50, ack); chk(!ack, "R8 restart then mismatch", ack, 0);
    send_byte(8'h77, ack); chk(!ack, "R8 ignored byte", ack, 0);
    bus_stop();
    lread(AW'(9), d); chk(d == model[9], "R8 register untouched", d, model[9]);

    // random traffic against the model
    for (int it = 0; it < 12; it++) begin
      int n;
      logic [7:0] ix;
      n  = 1 + int'($urandom_range(2));
      ix = 8'($urandom);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      bus_wr(1'b1, ix, n, "R5 random write ack");
      bus_rd(1'b1, 8'($urandom), 1 + int'($urandom_range(2)), "R6 random read");
    end

    chk(r9_viol == 0, "R9 no change in SCL high", r9_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule